// File: doc/BRIEF.md
# Serial Auto-Baud Lock Controller

This block sits on an asynchronous serial receive/transmit pair whose bit rate is not known in advance. After reset it waits until the receive line has been seen high. It then times the low runs that appear on that line while the host keeps sending the zero byte. Each zero byte in 8N1 format (eight data bits, one stop bit, no parity) gives one low run nine bit times long: the start bit and eight zero data bits. When two consecutive runs agree closely, the block works out a clock-per-bit divisor and holds it.

With the divisor locked, the block sends one zero byte back as a lock indication and then listens for a single reply byte. A correct 0x55 reply with a valid stop bit ends the handshake in a done state. Any other byte, or a frame whose stop bit is low, ends it in an error state. Both end states clear the transmit and receive enables, keep the divisor on its output for later traffic, and hold until reset. A low run that is too short or too long also ends in the error state. Every frame received with a good stop bit while the reply is awaited is also passed out as a one-cycle byte strobe.

Top module: `autobaud_ctrl`

## Requirements
- R1: In reset and right after it, txd is 1 and done, error, rx_valid, rx_en, tx_en and divisor are all 0.
- R2: No low run is timed until rxd has been seen high after reset, so a line held low from reset raises no error, however long it stays low.
- R3: A low run's length L is the number of clock cycles rxd stays low. Take two consecutive accepted runs L1 and L2 with |L2-L1|*32 <= L1. The locked divisor is then (L1+L2+9)/18 using integer division, which is their mean divided by 9 and rounded.
- R4: If two consecutive runs disagree by more than that tolerance, nothing is locked and no lock indication is sent. The newer run becomes the reference for the next comparison.
- R5: A low run shorter than MIN_LOW (16) cycles sets error. A run of exactly MIN_LOW is accepted.
- R6: If rxd stays low for more than MAX_LOW (4000) cycles during measurement, error is set while the line is still low.
- R7: After lock, exactly one frame is sent on txd. It is the byte 0x00 sent LSB first as start bit 0, data, stop bit 1, with divisor clock cycles per bit, so txd is low for exactly 9*divisor cycles. txd is 1 at all other times.
- R8: A reply byte of 0x55 received with a high stop bit (each bit sampled at its midpoint) sets done. The same byte appears once on rx_data with a one-cycle rx_valid strobe.
- R9: A reply of any byte other than 0x55 sets error and never done. That byte is still presented on rx_valid/rx_data.
- R10: A reply frame whose stop bit is sampled low sets error, and no rx_valid strobe is produced.
- R11: done and error are never both 1 and each holds until reset. Once either is set, further rxd activity changes neither flag nor the divisor, produces no rx_valid, and leaves txd at 1.
- R12: tx_en is 1 only while the lock indication frame is being sent, and rx_en only while the reply is awaited. Both are 0 after done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line from the host (asynchronous) |
| txd | output | 1 | Serial transmit line to the host, idles high |
| divisor | output | DIV_W | Locked clock cycles per bit, 0 until lock |
| done | output | 1 | Handshake completed successfully (sticky) |
| error | output | 1 | Out-of-range run or handshake failure (sticky) |
| rx_en | output | 1 | Receiver active, awaiting the reply byte |
| tx_en | output | 1 | Transmitter active, sending the lock indication |
| rx_valid | output | 1 | One-cycle strobe for a received frame with a good stop bit |
| rx_data | output | 8 | Received byte, valid with rx_valid |

## Verification
The bench holds rxd low straight out of reset for longer than the overlong limit. A design that timed runs before seeing the line high would raise a false error there. It feeds unequal run pairs whose mean is not a multiple of nine, which catches rounding and averaging mistakes in the divisor. It also feeds a disagreeing pair, which a design that accepts the first measurement would lock on. Runs one cycle on each side of the short-run limit, and a run held past the long-run limit, expose off-by-one range checks. The lock frame's low time is measured against nine times the divisor. Reply bytes that are wrong, that have a low stop bit, or that arrive after completion show whether the end states are truly sticky and quiet.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_HIGH,
        ST_MEASURE,
        ST_TX_ACK,
        ST_WAIT_55,
        ST_DONE,
        ST_ERROR
    } ab_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;

    localparam logic [7:0] LOCK_BYTE  = 8'h00;
    localparam logic [7:0] REPLY_BYTE = 8'h55;
    localparam int         ZERO_RUN_BITS = 9;

endpackage

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/autobaud_meter.sv
module autobaud_meter #(
    parameter int DIV_W     = 12,
    parameter int MIN_LOW   = 16,
    parameter int MAX_LOW   = 4000,
    parameter int TOL_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line,
    output logic             lock,
    output logic             range_err,
    output logic [DIV_W-1:0] div_out
);
    import autobaud_pkg::*;

    localparam int CNT_W = $clog2(MAX_LOW + 1);
    localparam int SUM_W = CNT_W + 2;
    localparam int AGR_W = CNT_W + TOL_SHIFT;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LOW);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW);
    localparam logic [SUM_W-1:0] RND     = SUM_W'(ZERO_RUN_BITS);
    localparam logic [SUM_W-1:0] DEN     = SUM_W'(2 * ZERO_RUN_BITS);

    typedef struct packed {
        logic             line_prev;
        logic             in_run;
        logic [CNT_W-1:0] cnt;
        logic             have_ref;
        logic [CNT_W-1:0] ref_len;
    } meter_s;

    meter_s m_d, m_q;
    logic [CNT_W-1:0] diff;
    logic [AGR_W-1:0] diff_sc;
    logic [SUM_W-1:0] pair_sum;
    logic             agree;

    always_comb begin
        diff     = (m_q.cnt > m_q.ref_len) ? (m_q.cnt - m_q.ref_len) : (m_q.ref_len - m_q.cnt);
        diff_sc  = AGR_W'(diff) << TOL_SHIFT;
        agree    = diff_sc <= AGR_W'(m_q.ref_len);
        pair_sum = SUM_W'(m_q.cnt) + SUM_W'(m_q.ref_len);
        div_out  = DIV_W'((pair_sum + RND) / DEN);
    end

    always_comb begin
        m_d           = m_q;
        m_d.line_prev = line;
        lock          = 1'b0;
        range_err     = 1'b0;
        if (!enable) begin
            m_d.in_run   = 1'b0;
            m_d.cnt      = '0;
            m_d.have_ref = 1'b0;
            m_d.ref_len  = '0;
        end else if (!m_q.in_run) begin
            if (m_q.line_prev && !line) begin
                m_d.in_run = 1'b1;
                m_d.cnt    = CNT_W'(1);
            end
        end else if (!line) begin
            if (m_q.cnt == MAX_CNT) range_err = 1'b1;
            else                    m_d.cnt   = m_q.cnt + 1'b1;
        end else begin
            m_d.in_run = 1'b0;
            if (m_q.cnt < MIN_CNT) begin
                range_err = 1'b1;
            end else if (m_q.have_ref && agree) begin
                lock = 1'b1;
            end else begin
                m_d.have_ref = 1'b1;
                m_d.ref_len  = m_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end
endmodule

// File: rtl/autobaud_tx.sv
module autobaud_tx #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] divisor,
    input  logic [7:0]       data,
    output logic             txd,
    output logic             busy,
    output logic             finish
);
    typedef struct packed {
        logic             busy;
        logic [9:0]       frame;
        logic [3:0]       bit_idx;
        logic [DIV_W-1:0] cnt;
    } tx_s;

    tx_s t_d, t_q;

    always_comb begin
        t_d    = t_q;
        finish = 1'b0;
        if (!t_q.busy) begin
            if (start) begin
                t_d.busy    = 1'b1;
                t_d.frame   = {1'b1, data, 1'b0};
                t_d.bit_idx = '0;
                t_d.cnt     = divisor - 1'b1;
            end
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end else if (t_q.bit_idx == 4'd9) begin
            t_d.busy = 1'b0;
            finish   = 1'b1;
        end else begin
            t_d.frame   = {1'b1, t_q.frame[9:1]};
            t_d.bit_idx = t_q.bit_idx + 1'b1;
            t_d.cnt     = divisor - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{busy: 1'b0, frame: '1, bit_idx: '0, cnt: '0};
        else        t_q <= t_d;
    end

    assign txd  = t_q.busy ? t_q.frame[0] : 1'b1;
    assign busy = t_q.busy;
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line,
    input  logic [DIV_W-1:0] divisor,
    output logic             valid,
    output logic             frame_err,
    output logic [7:0]       data
);
    import autobaud_pkg::*;

    typedef struct packed {
        rx_phase_e        phase;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bit_idx;
        logic [7:0]       shreg;
    } rx_s;

    rx_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        valid     = 1'b0;
        frame_err = 1'b0;
        if (!enable) begin
            r_d.phase = RX_IDLE;
        end else begin
            unique case (r_q.phase)
                RX_IDLE: begin
                    if (!line) begin
                        r_d.phase = RX_START;
                        r_d.cnt   = (divisor >> 1) - 1'b1;
                    end
                end
                RX_START: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else if (!line) begin
                        r_d.phase   = RX_DATA;
                        r_d.cnt     = divisor - 1'b1;
                        r_d.bit_idx = '0;
                    end else begin
                        r_d.phase = RX_IDLE;
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else begin
                        r_d.shreg = {line, r_q.shreg[7:1]};
                        r_d.cnt   = divisor - 1'b1;
                        if (r_q.bit_idx == 3'd7) r_d.phase = RX_STOP;
                        else                     r_d.bit_idx = r_q.bit_idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end else begin
                        valid     = line;
                        frame_err = !line;
                        r_d.phase = RX_IDLE;
                    end
                end
                default: r_d.phase = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{phase: RX_IDLE, cnt: '0, bit_idx: '0, shreg: '0};
        else        r_q <= r_d;
    end

    assign data = r_q.shreg;
endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl #(
    parameter int DIV_W       = 12,
    parameter int MIN_LOW     = 16,
    parameter int MAX_LOW     = 4000,
    parameter int TOL_SHIFT   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             txd,
    output logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic             error,
    output logic             rx_en,
    output logic             tx_en,
    output logic             rx_valid,
    output logic [7:0]       rx_data
);
    import autobaud_pkg::*;

    typedef struct packed {
        ab_state_e        state;
        logic [DIV_W-1:0] div;
    } ctrl_s;

    ctrl_s c_d, c_q;

    logic             line_s;
    logic             meas_en, m_lock, m_range_err;
    logic [DIV_W-1:0] m_div, tx_div;
    logic             tx_start, tx_busy, tx_finish;
    logic             rx_vld, rx_ferr;
    logic [7:0]       rx_byte;

    autobaud_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .din (rxd), .dout (line_s)
    );

    autobaud_meter #(
        .DIV_W (DIV_W), .MIN_LOW (MIN_LOW), .MAX_LOW (MAX_LOW), .TOL_SHIFT (TOL_SHIFT)
    ) u_meter (
        .clk (clk), .rst_n (rst_n), .enable (meas_en), .line (line_s),
        .lock (m_lock), .range_err (m_range_err), .div_out (m_div)
    );

    autobaud_tx #(.DIV_W(DIV_W)) u_tx (
        .clk (clk), .rst_n (rst_n), .start (tx_start), .divisor (tx_div),
        .data (LOCK_BYTE), .txd (txd), .busy (tx_busy), .finish (tx_finish)
    );

    autobaud_rx #(.DIV_W(DIV_W)) u_rx (
        .clk (clk), .rst_n (rst_n), .enable (rx_en), .line (line_s),
        .divisor (c_q.div), .valid (rx_vld), .frame_err (rx_ferr), .data (rx_byte)
    );

    always_comb begin
        meas_en  = (c_q.state == ST_MEASURE);
        tx_start = meas_en && m_lock && !m_range_err;
        tx_div   = meas_en ? m_div : c_q.div;
    end

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_WAIT_HIGH: if (line_s) c_d.state = ST_MEASURE;
            ST_MEASURE: begin
                if (m_range_err) begin
                    c_d.state = ST_ERROR;
                end else if (m_lock) begin
                    c_d.div   = m_div;
                    c_d.state = ST_TX_ACK;
                end
            end
            ST_TX_ACK: if (tx_finish) c_d.state = ST_WAIT_55;
            ST_WAIT_55: begin
                if (rx_ferr) c_d.state = ST_ERROR;
                else if (rx_vld) c_d.state = (rx_byte == REPLY_BYTE) ? ST_DONE : ST_ERROR;
            end
            ST_DONE:  c_d.state = ST_DONE;
            ST_ERROR: c_d.state = ST_ERROR;
            default:  c_d.state = ST_ERROR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_WAIT_HIGH, div: '0};
        else        c_q <= c_d;
    end

    assign divisor  = c_q.div;
    assign done     = (c_q.state == ST_DONE);
    assign error    = (c_q.state == ST_ERROR);
    assign rx_en    = (c_q.state == ST_WAIT_55);
    assign tx_en    = (c_q.state == ST_TX_ACK) && tx_busy;
    assign rx_valid = rx_vld && rx_en;
    assign rx_data  = rx_byte;
endmodule

// File: rtl/autobaud_ctrl_chk.sv
module autobaud_ctrl_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic [DIV_W-1:0] divisor,
    input logic             done,
    input logic             error,
    input logic             rx_en,
    input logic             tx_en,
    input logic             rx_valid,
    input logic [7:0]       rx_data
);
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    a_r11_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> $stable(divisor));

    a_r12_en_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en));

    a_r12_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!rx_en && !tx_en && !rx_valid));

    a_r7_txd_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd);

    a_r3_div_set_when_sending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (divisor != '0));

    a_r8_done_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(rx_valid) && $past(rx_data) == 8'h55));

    a_r8_valid_only_when_listening: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_en);
endmodule

bind autobaud_ctrl autobaud_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk (clk), .rst_n (rst_n), .txd (txd), .divisor (divisor),
    .done (done), .error (error), .rx_en (rx_en), .tx_en (tx_en),
    .rx_valid (rx_valid), .rx_data (rx_data)
);

// File: tb/autobaud_ctrl_tb.sv
module autobaud_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 12;
    localparam int WATCHDOG   = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic             txd, done, error, rx_en, tx_en, rx_valid;
    logic [DIV_W-1:0] divisor;
    logic [7:0]       rx_data;

    int tests = 0;
    int fails = 0;
    int txd_low_total = 0;
    int sticky_viol = 0;
    bit done_seen = 0;
    bit err_seen = 0;
    logic [7:0] rx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    autobaud_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .rxd (rxd), .txd (txd), .divisor (divisor),
        .done (done), .error (error), .rx_en (rx_en), .tx_en (tx_en),
        .rx_valid (rx_valid), .rx_data (rx_data)
    );

    // Behavioural observer: stream capture and sticky-flag model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) rx_q.push_back(rx_data);
            if (!txd) txd_low_total++;
            if ((done_seen && !done) || (err_seen && !error) || (done && error)) sticky_viol++;
            if (done) done_seen = 1;
            if (error) err_seen = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_div(input int l1, input int l2);
        return (l1 + l2 + 9) / 18;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic line);
        @(negedge clk);
        rst_n = 1'b0;
        rxd   = line;
        cycles(5);
        rx_q.delete();
        done_seen = 0;
        err_seen  = 0;
        rst_n = 1'b1;
    endtask

    task automatic low_run(input int len, input int hi);
        rxd = 1'b0;
        cycles(len);
        rxd = 1'b1;
        cycles(hi);
    endtask

    task automatic send_byte(input logic [7:0] b, input int bt, input logic stop_lvl);
        rxd = 1'b0;
        cycles(bt);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            cycles(bt);
        end
        rxd = stop_lvl;
        cycles(bt);
        rxd = 1'b1;
        cycles(bt);
    endtask

    task automatic wait_ack(input int expd);
        int t = 0;
        int len = 0;
        bit en_ok = 1;
        while (txd && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 1000, "R7 lock frame starts", t, 0);
        while (!txd && len < 20000) begin
            if (!tx_en) en_ok = 0;
            len++;
            @(negedge clk);
        end
        chk(len == 9 * expd, "R7 lock frame low time", len, 9 * expd);
        chk(en_ok, "R12 tx_en during lock frame", en_ok, 1);
        cycles(expd + 4);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("[TB] FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lowcnt;
        int nq;

        // R1 reset state, with R2 line low from reset
        do_reset(1'b0);
        chk(txd == 1'b1 && done == 0 && error == 0 && rx_valid == 0, "R1 reset outputs", {txd, done, error, rx_valid}, 4'b1000);
        chk(divisor == 0 && rx_en == 0 && tx_en == 0, "R1 reset divisor/enables", int'(divisor), 0);
        cycles(6000);
        chk(error == 0, "R2 low from reset ignored", error, 0);
        rxd = 1'b1;
        cycles(30);

        // R3 basic lock at bit period 20
        low_run(180, 20);
        low_run(180, 0);
        wait_ack(20);
        chk(divisor == exp_div(180, 180), "R3 divisor equal runs", int'(divisor), exp_div(180, 180));
        chk(rx_en == 1 && tx_en == 0, "R12 listening after lock frame", {rx_en, tx_en}, 2'b10);
        send_byte(8'h55, 20, 1'b1);
        cycles(5);
        chk(done == 1 && error == 0, "R8 reply 0x55 sets done", {done, error}, 2'b10);
        chk(rx_q.size() == 1 && rx_q[0] == 8'h55, "R8 reply byte on stream", rx_q.size(), 1);
        chk(rx_en == 0 && tx_en == 0, "R12 enables cleared at done", {rx_en, tx_en}, 0);

        // R11 activity after done is ignored
        lowcnt = txd_low_total;
        nq = rx_q.size();
        low_run(180, 20);
        low_run(180, 20);
        send_byte(8'h5A, 20, 1'b1);
        cycles(200);
        chk(done == 1 && error == 0 && divisor == 20, "R11 done state holds", int'(divisor), 20);
        chk(txd_low_total == lowcnt && rx_q.size() == nq, "R11 no tx/rx after done", txd_low_total - lowcnt, 0);

        // R3 rounding with unequal runs
        do_reset(1'b1);
        cycles(10);
        low_run(207, 23);
        low_run(212, 0);
        wait_ack(exp_div(207, 212));
        chk(divisor == exp_div(207, 212), "R3 divisor rounding", int'(divisor), exp_div(207, 212));
        send_byte(8'h55, 23, 1'b1);
        cycles(5);
        chk(done == 1, "R8 done at rounded divisor", done, 1);

        // R4 disagreement then R9 wrong reply
        do_reset(1'b1);
        cycles(10);
        low_run(180, 20);
        low_run(240, 30);
        chk(tx_en == 0 && txd == 1 && divisor == 0, "R4 no lock on disagreement", int'(divisor), 0);
        low_run(240, 0);
        wait_ack(exp_div(240, 240));
        chk(divisor == exp_div(240, 240), "R4 lock on next agreeing pair", int'(divisor), exp_div(240, 240));
        send_byte(8'h5A, 27, 1'b1);
        cycles(5);
        chk(error == 1 && done == 0, "R9 wrong reply sets error", {done, error}, 2'b01);
        chk(rx_q.size() == 1 && rx_q[0] == 8'h5A, "R9 wrong byte on stream", int'(rx_q[0]), 8'h5A);
        chk(divisor == 27 && rx_en == 0, "R12 divisor kept after error", int'(divisor), 27);

        // R10 framing error
        do_reset(1'b1);
        cycles(10);
        low_run(180, 20);
        low_run(180, 0);
        wait_ack(20);
        send_byte(8'h55, 20, 1'b0);
        cycles(5);
        chk(error == 1 && done == 0, "R10 low stop bit sets error", {done, error}, 2'b01);
        chk(rx_q.size() == 0, "R10 no strobe on bad frame", rx_q.size(), 0);

        // R5 boundary: MIN_LOW accepted, one below rejected
        do_reset(1'b1);
        cycles(10);
        low_run(16, 10);
        chk(error == 0, "R5 run of 16 accepted", error, 0);
        do_reset(1'b1);
        cycles(10);
        low_run(15, 10);
        chk(error == 1 && divisor == 0, "R5 run of 15 rejected", error, 1);

        // R6 overlong run flagged while still low
        do_reset(1'b1);
        cycles(10);
        rxd = 1'b0;
        cycles(3990);
        chk(error == 0, "R6 no error inside limit", error, 0);
        cycles(110);
        chk(error == 1 && rxd == 0, "R6 overlong run sets error", error, 1);
        rxd = 1'b1;
        cycles(10);

        chk(sticky_viol == 0, "R11 flags sticky and exclusive", sticky_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule